// File: doc/BRIEF.md
# Display timing generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB panel. It runs on the pixel clock. Static register-style inputs set the geometry of each axis and the output polarities. Each axis has four intervals: visible, front porch, sync, and a back-porch interval that includes the sync pulse. Every interval is held as its length minus one. Each blanking and sync phase has its own enable, so a phase of zero length is skipped entirely.

The generator starts on a rising edge of `arm`. With `auto_rpt` set it runs frames back to back. When either control is clear at the last cycle of a frame, the generator stops after that frame and raises `idle`. It also reports the current column and row, and gives one-cycle pulses at the start of each frame and at the start of a programmed line. A frame base address is staged by writes. The active copy changes only when a new frame begins.

Top module: `disp_timing_gen`

## Requirements
- R1: Each geometry word holds the column (horizontal) length minus one in bits 27:16 and the row (vertical) length minus one in bits 11:0. The words are the visible word, the sync word, the back-porch word and the front-porch word.
- R2: Within a line the order is visible, front porch, sync, then the rest of the back porch. When sync and back porch are both enabled, sync plus the rest of the back porch lasts back+1 cycles. The rest of the back porch never lasts less than one cycle.
- R3: A cleared phase enable (front porch, sync or back porch, per axis) removes that phase from the sequence entirely.
- R4: `de` is active only when both axes are in their visible phase. A set polarity bit inverts `de`, `hsync` or `vsync`, so 1 means active low.
- R5: The vertical axis follows the same phase order, counted in whole lines. `vsync` is active for complete lines.
- R6: `col` counts pixel clocks since the line began. `row` counts lines since the frame began. Both are 0 while idle.
- R7: `frame_start` is high for exactly the first cycle of every frame.
- R8: `line_match` is high in the first cycle of each line whose row equals `match_line`. A value beyond the frame height, such as 4095, never fires.
- R9: While idle, a rising edge of `arm` starts a frame. The first frame cycle follows the edge at which the rise is sampled. A rise of `arm` while running, or a level that is held high, starts nothing.
- R10: At the last cycle of a frame the next frame follows immediately if `arm` and `auto_rpt` are both high. Otherwise the generator stops and `idle` rises.
- R11: A write of `base_lo` commits the staged address, whose upper half is taken from `base_hi` writes. `frame_base` takes the committed value in the first cycle of the next frame and changes at no other time. A write in the last cycle before a frame is held for the frame after.
- R12: After reset the block is idle, `col`, `row` and `frame_base` are 0, and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_visible | input | 28 | Visible lengths minus one (column 27:16, row 11:0) |
| cfg_sync | input | 28 | Sync widths minus one |
| cfg_back | input | 28 | Sync plus back-porch lengths minus one |
| cfg_front | input | 28 | Front-porch lengths minus one |
| en_hfp | input | 1 | Horizontal front porch enable |
| en_hsync | input | 1 | Horizontal sync enable |
| en_hbp | input | 1 | Horizontal back porch enable |
| en_vfp | input | 1 | Vertical front porch enable |
| en_vsync | input | 1 | Vertical sync enable |
| en_vbp | input | 1 | Vertical back porch enable |
| pol_de | input | 1 | Invert data enable |
| pol_hs | input | 1 | Invert hsync |
| pol_vs | input | 1 | Invert vsync |
| arm | input | 1 | Start request (rising edge) and run permission |
| auto_rpt | input | 1 | Run frames back to back |
| match_line | input | 12 | Row for the line-match pulse |
| base_lo_we | input | 1 | Write and commit the lower address half |
| base_lo | input | 32 | Lower address half |
| base_hi_we | input | 1 | Write the upper address half |
| base_hi | input | 32 | Upper address half |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| col | output | 14 | Column within the line |
| row | output | 14 | Row within the frame |
| frame_start | output | 1 | First cycle of a frame |
| line_match | output | 1 | First cycle of the matched row |
| idle | output | 1 | Generator stopped |
| frame_base | output | 64 | Active frame base address |

## Verification
A wrong phase or count inside the horizontal sequencer shows up within one line as a shifted `hsync` or `de` edge, or as a wrong `col` value. A vertical error shows up by the next line boundary as a wrong `row` or `vsync`. A fault in the run control surfaces at the first frame boundary: `frame_start` goes missing or appears twice, or `idle` rises at the wrong time. A fault in the address shadow appears at the first `frame_start` after a write, or as a `frame_base` change in the middle of a frame. Comparing every port on every cycle against the reference model therefore pins each fault to the cycle where it first shows.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Phase of one axis; the numeric order is also the sequence order.
    typedef enum logic [1:0] {
        PH_ACT   = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } phase_e;

    // Field placement inside each geometry word.
    localparam int ROW_LSB = 0;
    localparam int COL_LSB = 16;

endpackage

// File: rtl/dtg_axis.sv
// One axis sequencer: visible, front, sync, remaining back porch.
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int POS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] act_m1,
    input  logic [CNT_W-1:0] fp_m1,
    input  logic [CNT_W-1:0] sync_m1,
    input  logic [CNT_W-1:0] bp_m1,
    input  logic             fp_en,
    input  logic             sync_en,
    input  logic             bp_en,
    output phase_e           phase,
    output logic [POS_W-1:0] pos,
    output logic             at_end
);

    localparam int CW = CNT_W + 1;

    typedef struct packed {
        phase_e           ph;
        logic [CW-1:0]    cnt;
        logic [POS_W-1:0] pos;
    } ax_st_t;

    ax_st_t st_d, st_q;

    logic          ph_done;
    phase_e        nxt_ph;
    logic [CW-1:0] nxt_cnt;

    always_comb begin
        ph_done = 1'b0;
        nxt_ph  = PH_ACT;
        nxt_cnt = '0;
        unique case (st_q.ph)
            PH_ACT: begin
                ph_done = (st_q.cnt == {1'b0, act_m1});
                if (fp_en)        nxt_ph = PH_FRONT;
                else if (sync_en) nxt_ph = PH_SYNC;
                else if (bp_en)   nxt_ph = PH_BACK;
                else              nxt_ph = PH_ACT;
            end
            PH_FRONT: begin
                ph_done = (st_q.cnt == {1'b0, fp_m1});
                if (sync_en)      nxt_ph = PH_SYNC;
                else if (bp_en)   nxt_ph = PH_BACK;
                else              nxt_ph = PH_ACT;
            end
            PH_SYNC: begin
                ph_done = (st_q.cnt == {1'b0, sync_m1});
                if (bp_en) begin
                    nxt_ph  = PH_BACK;
                    // back porch continues the count begun by sync
                    nxt_cnt = st_q.cnt + 1'b1;
                end else begin
                    nxt_ph  = PH_ACT;
                end
            end
            default: begin
                ph_done = (st_q.cnt >= {1'b0, bp_m1});
                nxt_ph  = PH_ACT;
            end
        endcase
        at_end = ph_done && (nxt_ph == PH_ACT);

        st_d = st_q;
        if (clear) begin
            st_d.ph  = PH_ACT;
            st_d.cnt = '0;
            st_d.pos = '0;
        end else if (step) begin
            if (ph_done) begin
                st_d.ph  = nxt_ph;
                st_d.cnt = nxt_cnt;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.pos = at_end ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_ACT;
            st_q.cnt <= '0;
            st_q.pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign pos   = st_q.pos;

endmodule

// File: rtl/dtg_shadow.sv
// Staged frame base address; the active copy moves only on commit.
module dtg_shadow #(
    parameter int LO_W = 32,
    parameter int HI_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_we,
    input  logic [LO_W-1:0]      lo_data,
    input  logic                 hi_we,
    input  logic [HI_W-1:0]      hi_data,
    input  logic                 commit,
    output logic [LO_W+HI_W-1:0] base
);

    typedef struct packed {
        logic [LO_W-1:0]      stage_lo;
        logic [HI_W-1:0]      stage_hi;
        logic                 pend;
        logic [LO_W+HI_W-1:0] act;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit && st_q.pend) begin
            st_d.act = {st_q.stage_hi, st_q.stage_lo};
        end
        if (hi_we) st_d.stage_hi = hi_data;
        if (lo_we) st_d.stage_lo = lo_data;
        // a write landing on the commit edge waits for the next frame
        st_d.pend = (st_q.pend && !commit) || lo_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base = st_q.act;

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int ADDR_LO_W = 32,
    parameter int ADDR_HI_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [COL_LSB+CNT_W-1:0]       cfg_visible,
    input  logic [COL_LSB+CNT_W-1:0]       cfg_sync,
    input  logic [COL_LSB+CNT_W-1:0]       cfg_back,
    input  logic [COL_LSB+CNT_W-1:0]       cfg_front,
    input  logic                           en_hfp,
    input  logic                           en_hsync,
    input  logic                           en_hbp,
    input  logic                           en_vfp,
    input  logic                           en_vsync,
    input  logic                           en_vbp,
    input  logic                           pol_de,
    input  logic                           pol_hs,
    input  logic                           pol_vs,
    input  logic                           arm,
    input  logic                           auto_rpt,
    input  logic [CNT_W-1:0]               match_line,
    input  logic                           base_lo_we,
    input  logic [ADDR_LO_W-1:0]           base_lo,
    input  logic                           base_hi_we,
    input  logic [ADDR_HI_W-1:0]           base_hi,
    output logic                           hsync,
    output logic                           vsync,
    output logic                           de,
    output logic [CNT_W+1:0]               col,
    output logic [CNT_W+1:0]               row,
    output logic                           frame_start,
    output logic                           line_match,
    output logic                           idle,
    output logic [ADDR_LO_W+ADDR_HI_W-1:0] frame_base
);

    localparam int POS_W  = CNT_W + 2;
    localparam int N_AXIS = 2;   // index 0 horizontal, 1 vertical

    typedef struct packed {
        logic run;
        logic arm_prev;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [N_AXIS-1:0] ax_step, ax_end, ax_fp_en, ax_sync_en, ax_bp_en;
    phase_e            ax_ph  [N_AXIS];
    logic [POS_W-1:0]  ax_pos [N_AXIS];
    logic              start, frame_end, keep_going, commit;

    assign ax_fp_en   = {en_vfp,   en_hfp};
    assign ax_sync_en = {en_vsync, en_hsync};
    assign ax_bp_en   = {en_vbp,   en_hbp};
    assign ax_step    = {st_q.run & ax_end[0], st_q.run};

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        localparam int LSB = (a == 0) ? COL_LSB : ROW_LSB;
        dtg_axis #(
            .CNT_W (CNT_W),
            .POS_W (POS_W)
        ) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (~st_q.run),
            .step    (ax_step[a]),
            .act_m1  (cfg_visible[LSB +: CNT_W]),
            .fp_m1   (cfg_front[LSB +: CNT_W]),
            .sync_m1 (cfg_sync[LSB +: CNT_W]),
            .bp_m1   (cfg_back[LSB +: CNT_W]),
            .fp_en   (ax_fp_en[a]),
            .sync_en (ax_sync_en[a]),
            .bp_en   (ax_bp_en[a]),
            .phase   (ax_ph[a]),
            .pos     (ax_pos[a]),
            .at_end  (ax_end[a])
        );
    end

    // run control
    always_comb begin
        start      = !st_q.run && arm && !st_q.arm_prev;
        frame_end  = st_q.run && ax_end[0] && ax_end[1];
        keep_going = arm && auto_rpt;
        commit     = start || (frame_end && keep_going);

        st_d          = st_q;
        st_d.arm_prev = arm;
        if (start)          st_d.run = 1'b1;
        else if (frame_end) st_d.run = keep_going;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dtg_shadow #(
        .LO_W (ADDR_LO_W),
        .HI_W (ADDR_HI_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (base_lo_we),
        .lo_data (base_lo),
        .hi_we   (base_hi_we),
        .hi_data (base_hi),
        .commit  (commit),
        .base    (frame_base)
    );

    // outputs, all driven from registered state plus static config
    assign de          = pol_de ^ (st_q.run && ax_ph[0] == PH_ACT && ax_ph[1] == PH_ACT);
    assign hsync       = pol_hs ^ (st_q.run && ax_ph[0] == PH_SYNC);
    assign vsync       = pol_vs ^ (st_q.run && ax_ph[1] == PH_SYNC);
    assign col         = ax_pos[0];
    assign row         = ax_pos[1];
    assign frame_start = st_q.run && ax_pos[0] == '0 && ax_pos[1] == '0;
    assign line_match  = st_q.run && ax_pos[0] == '0 &&
                         ax_pos[1] == {{(POS_W-CNT_W){1'b0}}, match_line};
    assign idle        = !st_q.run;

    logic unused_cfg_gap;
    assign unused_cfg_gap = ^{cfg_visible[COL_LSB-1:CNT_W], cfg_sync[COL_LSB-1:CNT_W],
                              cfg_back[COL_LSB-1:CNT_W],    cfg_front[COL_LSB-1:CNT_W]};

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
    parameter int CNT_W  = 12,
    parameter int POS_W  = 14,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              pol_de,
    input logic [CNT_W-1:0]  match_line,
    input logic              idle,
    input logic              de,
    input logic [POS_W-1:0]  col,
    input logic [POS_W-1:0]  row,
    input logic              frame_start,
    input logic              line_match,
    input logic [ADDR_W-1:0] frame_base
);

    p_de_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (de == pol_de));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (col == '0 && row == '0));

    p_fs_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!idle && col == '0 && row == '0));

    p_match_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_match |-> (col == '0 && row == {{(POS_W-CNT_W){1'b0}}, match_line}));

    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $rose(arm)) |=> frame_start);

    p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(frame_base));

endmodule

bind disp_timing_gen dtg_chk #(
    .CNT_W  (CNT_W),
    .POS_W  (POS_W),
    .ADDR_W (ADDR_LO_W + ADDR_HI_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .pol_de      (pol_de),
    .match_line  (match_line),
    .idle        (idle),
    .de          (de),
    .col         (col),
    .row         (row),
    .frame_start (frame_start),
    .line_match  (line_match),
    .frame_base  (frame_base)
);

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] cfg_visible = '0, cfg_sync = '0, cfg_back = '0, cfg_front = '0;
    logic        en_hfp = 1, en_hsync = 1, en_hbp = 1, en_vfp = 1, en_vsync = 1, en_vbp = 1;
    logic        pol_de = 0, pol_hs = 0, pol_vs = 0;
    logic        arm = 0, auto_rpt = 0;
    logic [11:0] match_line = 12'd4095;
    logic        base_lo_we = 0, base_hi_we = 0;
    logic [31:0] base_lo = '0, base_hi = '0;
    logic        hsync, vsync, de, frame_start, line_match, idle;
    logic [13:0] col, row;
    logic [63:0] frame_base;

    always #10 clk = ~clk;   // 50 MHz

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_visible(cfg_visible), .cfg_sync(cfg_sync), .cfg_back(cfg_back), .cfg_front(cfg_front),
        .en_hfp(en_hfp), .en_hsync(en_hsync), .en_hbp(en_hbp),
        .en_vfp(en_vfp), .en_vsync(en_vsync), .en_vbp(en_vbp),
        .pol_de(pol_de), .pol_hs(pol_hs), .pol_vs(pol_vs),
        .arm(arm), .auto_rpt(auto_rpt), .match_line(match_line),
        .base_lo_we(base_lo_we), .base_lo(base_lo), .base_hi_we(base_hi_we), .base_hi(base_hi),
        .hsync(hsync), .vsync(vsync), .de(de), .col(col), .row(row),
        .frame_start(frame_start), .line_match(line_match), .idle(idle), .frame_base(frame_base)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 0;
    string cfg_tag = "R1";

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_run = 0, m_armp = 0, m_pend = 0;
    int          m_hx = 0, m_vy = 0;
    logic [31:0] m_st_lo = '0, m_st_hi = '0;
    logic [63:0] m_base = '0;

    function automatic int fld(input logic [27:0] w, input int ax);
        return (ax == 0) ? int'(w[27:16]) : int'(w[11:0]);
    endfunction

    // lengths of the four phases of an axis
    function automatic void lens(input int ax, output int A, output int F, output int S, output int B);
        bit fe, se, be;
        int bp;
        fe = (ax == 0) ? en_hfp : en_vfp;
        se = (ax == 0) ? en_hsync : en_vsync;
        be = (ax == 0) ? en_hbp : en_vbp;
        A  = fld(cfg_visible, ax) + 1;
        F  = fe ? fld(cfg_front, ax) + 1 : 0;
        S  = se ? fld(cfg_sync, ax) + 1 : 0;
        bp = fld(cfg_back, ax);
        B  = be ? ((bp >= S) ? bp - S + 1 : 1) : 0;
    endfunction

    function automatic int ph_of(input int x, input int A, input int F, input int S);
        if (x < A) return 0;
        if (x < A + F) return 1;
        if (x < A + F + S) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        int hA, hF, hS, hB, vA, vF, vS, vB, hp, vp;
        bit commit;
        bit e_de, e_hs, e_vs, e_fs, e_lm;
        cyc++;
        lens(0, hA, hF, hS, hB);
        lens(1, vA, vF, vS, vB);
        if (!rst_n) begin
            m_run = 0; m_armp = 0; m_hx = 0; m_vy = 0;
            m_pend = 0; m_st_lo = '0; m_st_hi = '0; m_base = '0;
        end else begin
            commit = 0;
            if (!m_run) begin
                if (arm && !m_armp) begin m_run = 1; m_hx = 0; m_vy = 0; commit = 1; end
            end else begin
                m_hx++;
                if (m_hx == hA + hF + hS + hB) begin
                    m_hx = 0;
                    m_vy++;
                    if (m_vy == vA + vF + vS + vB) begin
                        m_vy = 0;
                        if (arm && auto_rpt) commit = 1;
                        else m_run = 0;
                    end
                end
            end
            m_armp = arm;
            if (commit && m_pend) m_base = {m_st_hi, m_st_lo};
            m_pend = (m_pend && !commit) || base_lo_we;
            if (base_hi_we) m_st_hi = base_hi;
            if (base_lo_we) m_st_lo = base_lo;
        end
        #5;
        if (rst_n && !done) begin
            hp   = ph_of(m_hx, hA, hF, hS);
            vp   = ph_of(m_vy, vA, vF, vS);
            e_de = pol_de ^ (m_run && hp == 0 && vp == 0);
            e_hs = pol_hs ^ (m_run && hp == 2);
            e_vs = pol_vs ^ (m_run && vp == 2);
            e_fs = m_run && m_hx == 0 && m_vy == 0;
            e_lm = m_run && m_hx == 0 && m_vy == int'(match_line);
            chk(idle == !m_run, {"R10 idle ", cfg_tag}, idle, !m_run);
            chk(de == e_de, {"R4 de ", cfg_tag}, de, e_de);
            chk(hsync == e_hs, {"R2 hsync ", cfg_tag}, hsync, e_hs);
            chk(vsync == e_vs, {"R5 vsync ", cfg_tag}, vsync, e_vs);
            chk(int'(col) == m_hx, {"R6 col ", cfg_tag}, col, m_hx);
            chk(int'(row) == m_vy, {"R6 row ", cfg_tag}, row, m_vy);
            chk(frame_start == e_fs, {"R7 frame_start ", cfg_tag}, frame_start, e_fs);
            chk(line_match == e_lm, {"R8 line_match ", cfg_tag}, line_match, e_lm);
            chk(frame_base == m_base, {"R11 frame_base ", cfg_tag}, frame_base, m_base);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [27:0] geo(input int c, input int r);
        return (28'(c) << 16) | 28'(r);
    endfunction

    task automatic wr_lo(input logic [31:0] v);
        base_lo = v; base_lo_we = 1;
        @(negedge clk) base_lo_we = 0;
    endtask

    task automatic wr_hi(input logic [31:0] v);
        base_hi = v; base_hi_we = 1;
        @(negedge clk) base_hi_we = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!idle && n < 2000) begin @(negedge clk); n++; end
        chk(idle == 1'b1, req, idle, 1);
    endtask

    initial begin
        int n_lm, n_fs;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk(idle == 1'b1, "R12 idle", idle, 1);
        chk(col == 0 && row == 0, "R12 col/row", {col, row}, 0);
        chk(frame_base == 0, "R12 frame_base", frame_base, 0);
        chk(frame_start == 0 && line_match == 0, "R12 pulses", {frame_start, line_match}, 0);

        // Scenario R1: field placement, all phases, repeat, address staging
        cfg_tag     = "R1";
        cfg_visible = geo(7, 3);
        cfg_front   = geo(1, 0);
        cfg_sync    = geo(2, 1);
        cfg_back    = geo(5, 2);
        match_line  = 12'd2;
        auto_rpt    = 1;
        wr_hi(32'hA5A5_0001);
        wr_lo(32'h1000_0000);
        arm = 1;   // R9 rising edge
        repeat (60) @(negedge clk);
        wr_hi(32'h0000_0002);
        wr_lo(32'h2000_0040);
        repeat (300) @(negedge clk);
        auto_rpt = 0;
        wait_idle("R10 stop after frame");
        repeat (30) @(negedge clk);
        chk(idle == 1'b1, "R9 held arm does not restart", idle, 1);

        // Scenario R3: skipped phases, inverted outputs, unreachable match
        arm         = 0;
        cfg_tag     = "R3";
        en_hfp      = 0;
        en_hsync    = 0;
        en_vbp      = 0;
        pol_de      = 1; pol_hs = 1; pol_vs = 1;
        match_line  = 12'd4095;
        @(negedge clk);
        arm = 1;
        n_lm = 0; n_fs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (line_match) n_lm++;
            if (frame_start) n_fs++;
            if (i % 37 == 5) begin base_lo = 32'(i); base_lo_we = 1; end
            else base_lo_we = 0;
        end
        base_lo_we = 0;
        chk(n_lm == 0, "R8 match 4095 never fires", n_lm, 0);
        chk(n_fs == 1, "R7 single-shot frame count", n_fs, 1);
        chk(idle == 1'b1, "R10 single shot stops", idle, 1);

        // Scenario R2: back porch shorter than sync, dense writes across frame edges
        arm         = 0;
        cfg_tag     = "R2";
        en_hfp = 1; en_hsync = 1; en_hbp = 1;
        en_vfp = 0; en_vsync = 1; en_vbp = 0;
        pol_de = 0; pol_hs = 1; pol_vs = 0;
        cfg_sync    = geo(3, 1);
        cfg_back    = geo(2, 2);
        match_line  = 12'd5;
        auto_rpt    = 1;
        @(negedge clk);
        arm = 1;
        for (int i = 0; i < 400; i++) begin
            base_lo = 32'hC000_0000 + 32'(i);
            base_lo_we = (i % 3 != 0);
            base_hi = 32'(i * 7);
            base_hi_we = (i % 5 == 0);
            @(negedge clk);
        end
        base_lo_we = 0; base_hi_we = 0;
        arm = 0;   // clearing arm alone also stops after the frame
        wait_idle("R10 stop on arm low");
        repeat (10) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule